// File: doc/BRIEF.md
# Linked Descriptor Queue Engine

This block runs one transfer queue, either transmit or receive, for a packet controller. Software builds a chain of 16-byte descriptors in memory. Each descriptor names a data buffer, a length and the address of the following descriptor. Software sets the hardware-own flag on each descriptor and then pulses `start`. The engine then reads each descriptor, one 32-bit word at a time, through a simple memory port. It gives the buffer to a downstream data mover through a request/done handshake. When the mover finishes, the engine writes status back to the descriptor and follows the link to the next one.

A descriptor holds four little-endian words:
- word 0: flags in bits 7:0, checksum in bits 15:8, receive capacity in bits 31:16;
- word 1: the link address;
- word 2: the buffer address;
- word 3: the length in bits 15:0, a spare byte in bits 23:16, and extended flags in bits 31:24.

In the flags byte, bit 0 means hardware-owned, bit 2 means skip, and bit 7 requests an interrupt on completion. Bit 1 is always zero, because each buffer is one flat region. Bit 5 of the extended flags asks for a zero-length packet after the data on transmit.

The controller is built around one state machine with eight states:
- **IDLE** waits for `start` and loads the queue base.
- **FETCH** reads words 0 to 3. After the last word it goes to CHECK.
- **CHECK** decides in one cycle, in this order:
  - not owned: go to PARK;
  - checksum enabled and the checksum fails: flag an error and go to IDLE;
  - skip flag set: go to ADVANCE;
  - otherwise: go to MOVE.
- **MOVE** holds the mover request until done. It then goes to WB_LEN in receive mode, or to WB_OWN in transmit mode.
- **WB_LEN** writes the received count into word 3, then goes to WB_OWN.
- **WB_OWN** rewrites word 0 with the own bit cleared, then goes to ADVANCE.
- **ADVANCE** goes to IDLE if a stop is pending. Otherwise it loads the link address and goes to FETCH.
- **PARK** goes to IDLE on a pending stop. It goes back to FETCH of the same descriptor on `resume`, or when the poll timer expires.

Top module: `ldq_engine`

## Requirements
- R1: After reset, `busy`, `parked`, `mem_req`, `xfer_req`, `irq_done` and `irq_csum` are all 0, and the engine stays idle until `start` is pulsed.
- R2: On `start`, the engine fetches the descriptor at `queue_base` as four word reads, at offsets 0, 4, 8 and 12 from the descriptor address. It decodes the fields by the word and bit layout given above.
- R3: A descriptor whose flags bit 0 is 0 is neither transferred nor written. The engine parks on it (`parked`=1, `cur_desc` unchanged) and reads it again when `resume` is pulsed.
- R4: While parked with `poll_interval` N>0, the engine reads the descriptor again every N cycles. With N=0 it reads it again only on `resume`.
- R5: An owned descriptor with flags bit 2 set is skipped. There is no transfer, no write and no interrupt, and the engine goes on to the linked descriptor.
- R6: With `csum_en`=1, an owned descriptor passes the check only if the modulo-256 sum of its 16 bytes is 0xFF. On a failure the engine pulses `irq_csum`, does no transfer and no write, and returns to idle. With `csum_en`=0 the checksum byte is ignored.
- R7: In transmit mode (`rx_mode`=0), `xfer_addr` is word 2, `xfer_len` is word 3 bits 15:0, and `xfer_zlp` is word 3 bit 29 (extended-flag bit 5).
- R8: In receive mode, `xfer_len` is word 0 bits 31:16 and `xfer_zlp` is 0. After done, the engine writes word 3 at offset 12 with `xfer_count` in bits 15:0 and bits 31:16 kept. This write comes before the flag write.
- R9: On completion, word 0 is written back with bit 0 cleared and every other bit of the word unchanged. This is the last write for that descriptor.
- R10: `irq_done` pulses for one cycle after a descriptor completes, if flags bit 7 was set in it. It does not pulse for skipped or failed descriptors.
- R11: After a completed or skipped descriptor, the next fetch is at the address in word 1.
- R12: A `stop` takes effect only at a descriptor boundary. A descriptor already in flight finishes its transfer and write-back, then the engine idles without fetching the next one. When parked, a stop idles the engine at once.
- R13: `mem_req` holds its address and direction until `mem_ack`, and `xfer_req` holds its address and length until `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start the queue at `queue_base` |
| stop | input | 1 | Request a halt at the next descriptor boundary |
| resume | input | 1 | Read the parked descriptor again |
| csum_en | input | 1 | Enable descriptor checksum checking |
| rx_mode | input | 1 | 1 = receive queue, 0 = transmit queue (sampled at start) |
| queue_base | input | ADDR_W | Byte address of the first descriptor |
| poll_interval | input | POLL_W | Re-read period while parked, 0 = off |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| xfer_req | output | 1 | Buffer request to the data mover |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_len | output | 16 | Bytes to send, or buffer capacity on receive |
| xfer_zlp | output | 1 | Send a zero-length packet after the data |
| xfer_done | input | 1 | Data mover finished |
| xfer_count | input | 16 | Bytes received, valid with `xfer_done` |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_csum | output | 1 | Checksum-error interrupt pulse |
| busy | output | 1 | Engine not idle |
| parked | output | 1 | Waiting on a descriptor that software owns |
| cur_desc | output | ADDR_W | Address of the current descriptor |

## Verification
Each wrong state shows at the ports within a few cycles:
- A wrong word index during fetch makes the field decode wrong. This shows at once in `xfer_addr`, `xfer_len` and `xfer_zlp`, in the first transfer after the fetch.
- A wrong decision in CHECK shows within one descriptor time. It shows as an extra or missing mover request, a missing `irq_csum`, or a `cur_desc` left on the wrong address.
- Write-back errors show in memory as soon as the descriptor retires. Examples are a wrong offset, an own bit left set, or the length written after the flag word.
- A stop taken in the wrong state shows as a descriptor that keeps its own bit although it was transferred, or as a second transfer after the stop.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_MOVE,
        ST_WB_LEN,
        ST_WB_OWN,
        ST_ADVANCE,
        ST_PARK
    } ldq_state_e;

    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned DESC_BYTES = DESC_WORDS * 4;
    localparam int unsigned DESC_BITS  = DESC_BYTES * 8;
    localparam int unsigned LEN_W      = 16;

    localparam int unsigned FLG_OWN    = 0;
    localparam int unsigned FLG_SKIP   = 2;
    localparam int unsigned FLG_IRQ    = 7;
    localparam int unsigned EXT_ZLP    = 5;

    localparam logic [7:0] CSUM_GOOD   = 8'hFF;

endpackage

// File: rtl/ldq_desc_regs.sv
module ldq_desc_regs
    import ldq_pkg::*;
#(
    parameter int unsigned WORDS = DESC_WORDS,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en,
    input  logic [IDX_W-1:0]      load_idx,
    input  logic [31:0]           load_data,
    output logic [WORDS*32-1:0]   desc_flat
);

    // One holding register per descriptor word; word k lands at bits 32k+.
    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (load_en && (load_idx == IDX_W'(gi))) begin
                word_q <= load_data;
            end
        end
        assign desc_flat[gi*32 +: 32] = word_q;
    end

endmodule

// File: rtl/ldq_csum.sv
module ldq_csum
    import ldq_pkg::*;
#(
    parameter int unsigned NBYTES = DESC_BYTES
) (
    input  logic [NBYTES*8-1:0] desc_flat,
    output logic                sum_ok
);

    logic [7:0] byte_v [NBYTES];
    logic [7:0] total;

    for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
        assign byte_v[gb] = desc_flat[gb*8 +: 8];
    end

    always_comb begin
        total = 8'h00;
        for (int k = 0; k < NBYTES; k++) begin
            total = total + byte_v[k];
        end
    end

    assign sum_ok = (total == CSUM_GOOD);

endmodule

// File: rtl/ldq_poll_timer.sv
module ldq_poll_timer #(
    parameter int unsigned POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [POLL_W-1:0] limit,
    output logic              fire
);

    logic [POLL_W-1:0] cnt_q;
    logic              active;

    assign active = run && (limit != '0);
    assign fire   = active && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < limit)); // R4

endmodule

// File: rtl/ldq_engine.sv
module ldq_engine
    import ldq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              resume,
    input  logic              csum_en,
    input  logic              rx_mode,
    input  logic [ADDR_W-1:0] queue_base,
    input  logic [POLL_W-1:0] poll_interval,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_zlp,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_count,
    output logic              irq_done,
    output logic              irq_csum,
    output logic              busy,
    output logic              parked,
    output logic [ADDR_W-1:0] cur_desc
);

    localparam int unsigned IDX_W    = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);
    localparam logic [ADDR_W-1:0] LEN_OFS = ADDR_W'(12);

    ldq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  widx_q;
    logic [ADDR_W-1:0] cur_q;
    logic              rxm_q;
    logic              stop_pend_q;
    logic              stop_any;
    logic [LEN_W-1:0]  rcv_q;
    logic              irq_done_q, irq_csum_q;

    logic [DESC_BITS-1:0] desc_flat;
    logic                 sum_ok;
    logic                 poll_fire;
    logic                 load_en;

    // field decode
    logic [7:0]        f_flags;
    logic [LEN_W-1:0]  f_cap;
    logic [31:0]       f_next;
    logic [31:0]       f_buf;
    logic [LEN_W-1:0]  f_len;
    logic [7:0]        f_ext;
    logic [31:0]       f_w0;
    logic [31:0]       f_w3;
    logic              own, skip, want_irq, csum_bad;

    assign f_w0     = desc_flat[31:0];
    assign f_w3     = desc_flat[127:96];
    assign f_flags  = f_w0[7:0];
    assign f_cap    = f_w0[31:16];
    assign f_next   = desc_flat[63:32];
    assign f_buf    = desc_flat[95:64];
    assign f_len    = f_w3[15:0];
    assign f_ext    = f_w3[31:24];
    assign own      = f_flags[FLG_OWN];
    assign skip     = f_flags[FLG_SKIP];
    assign want_irq = f_flags[FLG_IRQ];
    assign csum_bad = csum_en && !sum_ok;
    assign stop_any = stop_pend_q || stop;
    assign load_en  = (state_q == ST_FETCH) && mem_ack;

    ldq_desc_regs #(.WORDS(DESC_WORDS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_idx  (widx_q),
        .load_data (mem_rdata),
        .desc_flat (desc_flat)
    );

    ldq_csum #(.NBYTES(DESC_BYTES)) u_csum (
        .desc_flat (desc_flat),
        .sum_ok    (sum_ok)
    );

    ldq_poll_timer #(.POLL_W(POLL_W)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_PARK),
        .limit (poll_interval),
        .fire  (poll_fire)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_FETCH;
            ST_FETCH:   if (mem_ack && widx_q == LAST_IDX) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!own)          state_d = ST_PARK;
                else if (csum_bad) state_d = ST_IDLE;
                else if (skip)     state_d = ST_ADVANCE;
                else               state_d = ST_MOVE;
            end
            ST_MOVE:    if (xfer_done) state_d = rxm_q ? ST_WB_LEN : ST_WB_OWN;
            ST_WB_LEN:  if (mem_ack) state_d = ST_WB_OWN;
            ST_WB_OWN:  if (mem_ack) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = stop_any ? ST_IDLE : ST_FETCH;
            ST_PARK: begin
                if (stop_any)                state_d = ST_IDLE;
                else if (resume || poll_fire) state_d = ST_FETCH;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        xfer_req  = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + ADDR_W'({widx_q, 2'b00});
            end
            ST_WB_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + LEN_OFS;
                mem_wdata = {f_w3[31:16], rcv_q};
            end
            ST_WB_OWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = f_w0 & ~(32'h1 << FLG_OWN);
            end
            ST_MOVE:  xfer_req = 1'b1;
            default: ;
        endcase
    end

    assign xfer_addr = f_buf[ADDR_W-1:0];
    assign xfer_len  = rxm_q ? f_cap : f_len;
    assign xfer_zlp  = !rxm_q && f_ext[EXT_ZLP];
    assign irq_done  = irq_done_q;
    assign irq_csum  = irq_csum_q;
    assign busy      = (state_q != ST_IDLE);
    assign parked    = (state_q == ST_PARK);
    assign cur_desc  = cur_q;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx_q      <= '0;
            cur_q       <= '0;
            rxm_q       <= 1'b0;
            stop_pend_q <= 1'b0;
            rcv_q       <= '0;
            irq_done_q  <= 1'b0;
            irq_csum_q  <= 1'b0;
        end else begin
            if (state_q != ST_FETCH)  widx_q <= '0;
            else if (mem_ack)         widx_q <= widx_q + 1'b1;

            if (state_q == ST_IDLE && start) begin
                cur_q <= queue_base;
                rxm_q <= rx_mode;
            end else if (state_q == ST_ADVANCE && !stop_any) begin
                cur_q <= f_next[ADDR_W-1:0];
            end

            if (state_q == ST_IDLE) stop_pend_q <= 1'b0;
            else if (stop)          stop_pend_q <= 1'b1;

            if (state_q == ST_MOVE && xfer_done) rcv_q <= xfer_count;

            irq_done_q <= (state_q == ST_WB_OWN) && mem_ack && want_irq;
            irq_csum_q <= (state_q == ST_CHECK) && own && csum_bad;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !xfer_req)); // R1

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13

    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len))); // R13

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && xfer_req)); // R13

    AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == cur_q) |-> !mem_wdata[FLG_OWN]); // R9

    AST_STOP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(state_q) == ST_ADVANCE || $past(state_q) == ST_PARK
                         || $past(state_q) == ST_CHECK)); // R12

    AST_CSUM_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_csum |-> (!busy && !irq_done)); // R6

endmodule

// File: tb/ldq_engine_test.sv
module ldq_engine_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, stop, resume, csum_en, rx_mode;
    logic [31:0] queue_base;
    logic [15:0] poll_interval;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        xfer_req, xfer_zlp, xfer_done;
    logic [31:0] xfer_addr;
    logic [15:0] xfer_len, xfer_count;
    logic        irq_done, irq_csum, busy, parked;
    logic [31:0] cur_desc;

    always #10 clk = ~clk;

    ldq_engine #(.ADDR_W(32), .POLL_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .resume(resume),
        .csum_en(csum_en), .rx_mode(rx_mode), .queue_base(queue_base),
        .poll_interval(poll_interval),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_zlp(xfer_zlp), .xfer_done(xfer_done), .xfer_count(xfer_count),
        .irq_done(irq_done), .irq_csum(irq_csum), .busy(busy), .parked(parked),
        .cur_desc(cur_desc)
    );

    // memory model: 64 words, zero-wait acknowledge
    logic [31:0] mem [64];
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;

    // data mover model: done three cycles into a request
    logic [1:0]  mv_cnt;
    logic [15:0] rx_value;
    assign xfer_count = rx_value;
    always @(posedge clk) begin
        if (!rst_n) begin
            xfer_done <= 1'b0;
            mv_cnt    <= '0;
        end else if (xfer_done) begin
            xfer_done <= 1'b0;
            mv_cnt    <= '0;
        end else if (xfer_req) begin
            if (mv_cnt == 2'd2) xfer_done <= 1'b1;
            else                mv_cnt <= mv_cnt + 1'b1;
        end
    end

    // observation
    int          n_xfer, n_irqd, n_irqc, n_wr;
    logic [31:0] wr_log [8];
    logic [31:0] xa_log [8];
    logic [15:0] last_len;
    logic        last_zlp;
    int          tests, fails, cyc;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (xfer_req && xfer_done) begin
                if (n_xfer < 8) xa_log[n_xfer] = xfer_addr;
                last_len = xfer_len;
                last_zlp = xfer_zlp;
                n_xfer++;
            end
            if (mem_req && mem_we) begin
                if (n_wr < 8) wr_log[n_wr] = mem_addr;
                n_wr++;
            end
            if (irq_done) n_irqd++;
            if (irq_csum) n_irqc++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 0; stop = 0; resume = 0;
        wait_cyc(2);
        rst_n = 1'b1;
        n_xfer = 0; n_irqd = 0; n_irqc = 0; n_wr = 0;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic fix_csum(input int wi, input bit good);
        logic [7:0] s;
        s = 8'h00;
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 4; j++)
                if (!(k == 0 && j == 1)) s = s + mem[wi+k][j*8 +: 8];
        mem[wi][15:8] = 8'hFF - s + (good ? 8'h00 : 8'h01);
    endtask

    task automatic mk_desc(input int wi, input logic [7:0] fl, input logic [15:0] cap,
                           input logic [31:0] nx, input logic [31:0] bf,
                           input logic [15:0] ln, input logic [7:0] rsv,
                           input logic [7:0] ext, input bit good);
        mem[wi]   = {cap, 8'h00, fl};
        mem[wi+1] = nx;
        mem[wi+2] = bf;
        mem[wi+3] = {ext, rsv, ln};
        fix_csum(wi, good);
    endtask

    initial begin
        tests = 0; fails = 0; cyc = 0;
        rst_n = 0; start = 0; stop = 0; resume = 0;
        csum_en = 0; rx_mode = 0; queue_base = 32'h0; poll_interval = 16'h0;
        rx_value = 16'h0;
        do_reset();

        // R1: reset state
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 reqs", {30'b0, mem_req, xfer_req}, 0);
        chk("R1 irqs", {30'b0, irq_done, irq_csum}, 0);
        wait_cyc(5);
        chk("R1 idle", {30'b0, busy, parked}, 0);

        // R2 R3 R5 R6 R7 R9 R10 R11: sweep of flag / checksum combinations
        for (int f = 0; f < 32; f++) begin
            logic [7:0] fl;
            logic [31:0] w0_orig;
            bit own, byp, ioc, cen, good, e_err, e_x;
            own = f[0]; byp = f[1]; ioc = f[2]; cen = f[3]; good = f[4];
            do_reset();
            fl = {ioc, 4'b0000, byp, 1'b0, own};
            mk_desc(0, fl, 16'h0, 32'h10, 32'h1000 + f, 16'h20 + 16'(f), 8'h33,
                    {2'b00, f[0] ^ f[2], 5'b0}, good);
            mk_desc(4, 8'h00, 16'h0, 32'h00, 32'h2000, 16'h1, 8'h0, 8'h0, 1'b1);
            w0_orig = mem[0];
            csum_en = cen;
            pulse_start();
            wait_cyc(40);
            e_err = own && cen && !good;
            e_x   = own && !e_err && !byp;
            chk($sformatf("R6 csum irq f=%0d", f), n_irqc, e_err ? 1 : 0);
            chk($sformatf("R5 xfer count f=%0d", f), n_xfer, e_x ? 1 : 0);
            chk($sformatf("R10 done irq f=%0d", f), n_irqd, (e_x && ioc) ? 1 : 0);
            chk($sformatf("R9 word0 f=%0d", f), mem[0], e_x ? (w0_orig & ~32'h1) : w0_orig);
            chk($sformatf("R11 cur f=%0d", f), cur_desc, (own && !e_err) ? 32'h10 : 32'h0);
            chk($sformatf("R3 parked f=%0d", f), {31'b0, parked}, e_err ? 0 : 1);
            if (e_x) begin
                chk($sformatf("R7 addr f=%0d", f), xa_log[0], 32'h1000 + f);
                chk($sformatf("R7 len f=%0d", f), {16'b0, last_len}, 32'h20 + f);
                chk($sformatf("R7 zlp f=%0d", f), {31'b0, last_zlp}, {31'b0, f[0] ^ f[2]});
                chk($sformatf("R2 writes f=%0d", f), n_wr, 1);
            end else begin
                chk($sformatf("R5 no writes f=%0d", f), n_wr, 0);
            end
            stop = 1'b1; @(negedge clk); stop = 1'b0;
            wait_cyc(4);
            chk($sformatf("R12 parked stop f=%0d", f), {31'b0, busy}, 0);
        end
        csum_en = 0;

        // R3: resume re-reads a parked descriptor; R4: no polling when interval is 0
        do_reset();
        mk_desc(0, 8'h00, 16'h0, 32'h10, 32'hA0, 16'h8, 8'h0, 8'h0, 1'b1);
        pulse_start();
        wait_cyc(30);
        chk("R3 no transfer unowned", n_xfer, 0);
        mem[0][0] = 1'b1;
        wait_cyc(40);
        chk("R4 no poll at zero interval", n_xfer, 0);
        resume = 1'b1; @(negedge clk); resume = 1'b0;
        wait_cyc(30);
        chk("R3 transfer after resume", n_xfer, 1);

        // R4: polling picks up ownership without resume
        do_reset();
        poll_interval = 16'd6;
        mk_desc(0, 8'h00, 16'h0, 32'h10, 32'hA0, 16'h8, 8'h0, 8'h0, 1'b1);
        pulse_start();
        wait_cyc(20);
        chk("R4 parked before own", {31'b0, parked}, 1);
        mem[0][0] = 1'b1;
        wait_cyc(40);
        chk("R4 transfer via poll", n_xfer, 1);
        poll_interval = 16'd0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        wait_cyc(4);

        // R12: stop during transfer completes the descriptor, then idles
        do_reset();
        mk_desc(0, 8'h81, 16'h0, 32'h10, 32'hA0, 16'h8, 8'h0, 8'h0, 1'b1);
        mk_desc(4, 8'h01, 16'h0, 32'h00, 32'hB0, 16'h8, 8'h0, 8'h0, 1'b1);
        pulse_start();
        while (!xfer_req) @(negedge clk);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        wait_cyc(30);
        chk("R12 one transfer", n_xfer, 1);
        chk("R12 own released", {31'b0, mem[0][0]}, 0);
        chk("R12 next untouched", {31'b0, mem[4][0]}, 1);
        chk("R12 idle", {31'b0, busy}, 0);
        chk("R10 irq on stop path", n_irqd, 1);

        // R8: receive write-back order and field
        do_reset();
        rx_mode = 1'b1;
        rx_value = 16'h0023;
        mk_desc(0, 8'h01, 16'h0040, 32'h10, 32'hC0, 16'h0, 8'h5A, 8'hA5, 1'b1);
        pulse_start();
        wait_cyc(40);
        chk("R8 len is capacity", {16'b0, last_len}, 32'h40);
        chk("R8 zlp off on rx", {31'b0, last_zlp}, 0);
        chk("R8 word3", mem[3], 32'hA55A0023);
        chk("R8 writes", n_wr, 2);
        chk("R8 first write", wr_log[0], 32'h0C);
        chk("R9 last write", wr_log[1], 32'h00);
        rx_mode = 1'b0;
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        wait_cyc(4);

        // R11: chain across scattered addresses
        do_reset();
        mk_desc(0,  8'h01, 16'h0, 32'h30, 32'hA0, 16'h4, 8'h0, 8'h0, 1'b1);
        mk_desc(12, 8'h01, 16'h0, 32'h20, 32'hB0, 16'h4, 8'h0, 8'h0, 1'b1);
        mk_desc(8,  8'h01, 16'h0, 32'h10, 32'hC0, 16'h4, 8'h0, 8'h0, 1'b1);
        mk_desc(4,  8'h00, 16'h0, 32'h00, 32'hD0, 16'h4, 8'h0, 8'h0, 1'b1);
        pulse_start();
        wait_cyc(80);
        chk("R11 chain count", n_xfer, 3);
        chk("R11 first", xa_log[0], 32'hA0);
        chk("R11 second", xa_log[1], 32'hB0);
        chk("R11 third", xa_log[2], 32'hC0);
        chk("R11 parked at end", cur_desc, 32'h10);

        finish_run();
    end

endmodule